// File: doc/BRIEF.md
# Geometric Spike Feature Extractor

This block reduces one captured spike waveform to three small geometric features: the peak-to-valley amplitude, the steepest rise between neighbouring samples, and the signed area of the opening half-cycle. An upstream detector delivers the window as a stream of signed 12-bit samples. A start flag marks the first sample and an end flag marks the last. A downstream classifier reads the three features when a one-cycle strobe fires.

All arithmetic is built from adders, subtractors, accumulators and magnitude comparators. No multiplier is used. The opening half-cycle begins at the first sample and keeps the sign of that sample. It ends just before the first sample whose sign differs, or at the end of the window if the sign never changes. A sample counts as negative when bit 11 is set; zero counts as non-negative.

Top module: `spike_geom_features`

## Requirements
- R1: featP2V (13-bit unsigned) equals the largest accepted sample of the window minus the smallest one.
- R2: featSlope (13-bit signed) equals the largest value of x[n]-x[n-1] over consecutive accepted samples of the window. A window with one sample reports -4096, the most negative value.
- R3: featArea (18-bit signed) equals the sum of the samples from the first sample up to, but not including, the first sample whose sign bit (bit 11) differs from the first sample's sign bit. If no sample differs, it is the sum of the whole window. A window of 64 full-scale samples does not overflow.
- R4: featValid is high for exactly one cycle: the cycle after the clock edge that accepts the end sample. The three features keep their values until the next featValid.
- R5: A new window may start on the cycle right after an end sample. Its result is independent of the previous window.
- R6: A cycle with sampleValid low has no effect. A valid sample that arrives while no window is open and winStart is low has no effect.
- R7: A sample with winStart high while a window is open restarts the window and discards the earlier samples.
- R8: After reset, featValid is 0 and all three features are 0.
- R9: A sample with winStart and winEnd both high forms a complete one-sample window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Sample on sampleData is present this cycle |
| sampleData | input | 12 | Signed two's-complement sample |
| winStart | input | 1 | Marks the first sample of a window |
| winEnd | input | 1 | Marks the last sample of a window |
| featValid | output | 1 | One-cycle strobe: features are fresh |
| featP2V | output | 13 | Peak-to-valley amplitude, unsigned |
| featSlope | output | 13 | Maximum consecutive difference, signed |
| featArea | output | 18 | Signed area of the first half-cycle |

## Verification
The bench aims at the sign-bit boundary of the half-cycle, because zero must count as non-negative. A design that treated zero as a sign change would cut the area short. It drives 64 samples at both full-scale extremes: an accumulator that is too narrow would wrap the area to the wrong sign. It sends one-sample windows, where a slope register left at its reset value or loaded with zero would report 0 instead of -4096. It also covers back-to-back windows, idle gaps inside a window, stray samples outside any window, and restarts. Any leftover state or a missed gate would show up in these cases as features mixed from two windows.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  // Strobes from window control to the feature datapath
  typedef struct packed {
    logic load;    // accept first sample of a window
    logic update;  // accept a following sample
    logic close;   // accepted sample is the last of the window
  } sfeCtrl_t;
endpackage

// File: rtl/sfe_control.sv
module sfe_control
  import sfe_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sampleValid,
  input  logic     winStart,
  input  logic     winEnd,
  output sfeCtrl_t ctrl
);
  logic inWin;
  logic takeFirst, takeNext;

  assign takeFirst = sampleValid && winStart;
  assign takeNext  = sampleValid && inWin && !winStart;

  always_comb begin
    ctrl.load   = takeFirst;
    ctrl.update = takeNext;
    ctrl.close  = (takeFirst || takeNext) && winEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             inWin <= 1'b0;
    else if (ctrl.close)   inWin <= 1'b0;
    else if (takeFirst)    inWin <= 1'b1;
  end

  // A window opens only through a start-marked sample (R5, R7)
  p_open_by_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inWin) |-> $past(sampleValid && winStart));

  // Load and update never fire together (R7)
  p_one_accept_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.load && ctrl.update));
endmodule

// File: rtl/sfe_datapath.sv
module sfe_datapath
  import sfe_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int MAX_SAMPLES = 64,
  localparam int DW = SAMPLE_W + 1,
  localparam int AW = SAMPLE_W + $clog2(MAX_SAMPLES)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  sfeCtrl_t                   ctrl,
  input  logic signed [SAMPLE_W-1:0] x,
  output logic                       featValid,
  output logic        [DW-1:0]       featP2V,
  output logic signed [DW-1:0]       featSlope,
  output logic signed [AW-1:0]       featArea
);
  localparam logic signed [DW-1:0] SLOPE_FLOOR = {1'b1, {SAMPLE_W{1'b0}}};

  logic signed [SAMPLE_W-1:0] maxV, minV, prevV, nMax, nMin, nPrev;
  logic signed [DW-1:0]       slopeV, nSlope, diff;
  logic signed [AW-1:0]       areaV, nArea, xWide;
  logic                       halfOpen, nHalf, refSign, nRef;

  assign diff  = {x[SAMPLE_W-1], x} - {prevV[SAMPLE_W-1], prevV};
  assign xWide = {{(AW-SAMPLE_W){x[SAMPLE_W-1]}}, x};

  always_comb begin
    nMax = maxV; nMin = minV; nPrev = prevV; nSlope = slopeV;
    nArea = areaV; nHalf = halfOpen; nRef = refSign;
    if (ctrl.load) begin
      nMax = x; nMin = x; nPrev = x; nSlope = SLOPE_FLOOR;
      nArea = xWide; nHalf = 1'b1; nRef = x[SAMPLE_W-1];
    end else if (ctrl.update) begin
      if (x > maxV)      nMax = x;
      if (x < minV)      nMin = x;
      if (diff > slopeV) nSlope = diff;
      nPrev = x;
      if (halfOpen) begin
        if (x[SAMPLE_W-1] != refSign) nHalf = 1'b0;
        else                          nArea = areaV + xWide;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maxV <= '0; minV <= '0; prevV <= '0; slopeV <= SLOPE_FLOOR;
      areaV <= '0; halfOpen <= 1'b0; refSign <= 1'b0;
    end else begin
      maxV <= nMax; minV <= nMin; prevV <= nPrev; slopeV <= nSlope;
      areaV <= nArea; halfOpen <= nHalf; refSign <= nRef;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      featValid <= 1'b0; featP2V <= '0; featSlope <= '0; featArea <= '0;
    end else begin
      featValid <= ctrl.close;
      if (ctrl.close) begin
        featP2V   <= {nMax[SAMPLE_W-1], nMax} - {nMin[SAMPLE_W-1], nMin};
        featSlope <= nSlope;
        featArea  <= nArea;
      end
    end
  end

  // Amplitude cannot exceed the full sample span (R1)
  p_p2v_span_r1: assert property (@(posedge clk) disable iff (!rstN)
    featValid |-> featP2V < DW'(1 << SAMPLE_W));

  // A single step can never rise more than the whole amplitude (R2)
  p_slope_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    featValid |-> $signed({featSlope[DW-1], featSlope}) <= $signed({1'b0, featP2V}));

  // Area keeps the sign of the first sample: no overflow (R3)
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    featValid |-> (featArea[AW-1] == refSign) || (featArea == '0));
endmodule

// File: rtl/spike_geom_features.sv
module spike_geom_features
  import sfe_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int MAX_SAMPLES = 64,
  localparam int DW = SAMPLE_W + 1,
  localparam int AW = SAMPLE_W + $clog2(MAX_SAMPLES)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleData,
  input  logic                       winStart,
  input  logic                       winEnd,
  output logic                       featValid,
  output logic        [DW-1:0]       featP2V,
  output logic signed [DW-1:0]       featSlope,
  output logic signed [AW-1:0]       featArea
);
  sfeCtrl_t ctrl;

  sfe_control u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .winStart(winStart), .winEnd(winEnd), .ctrl(ctrl)
  );

  sfe_datapath #(.SAMPLE_W(SAMPLE_W), .MAX_SAMPLES(MAX_SAMPLES)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .x(sampleData),
    .featValid(featValid), .featP2V(featP2V),
    .featSlope(featSlope), .featArea(featArea)
  );

  // Strobe only follows an accepted end sample (R4)
  p_valid_after_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    featValid |-> $past(sampleValid && winEnd));
endmodule

// File: tb/tb_spike_geom_features.sv
module tb_spike_geom_features;
  logic clk = 0, rstN = 0;
  logic sampleValid = 0, winStart = 0, winEnd = 0;
  logic signed [11:0] sampleData = '0;
  logic featValid;
  logic [12:0] featP2V;
  logic signed [12:0] featSlope;
  logic signed [17:0] featArea;

  spike_geom_features dut (.*);

  always #2 clk = ~clk;

  int nTests = 0, nFail = 0;
  int wbuf [0:63];
  int wlen;
  int expP2V, expSlope, expArea;
  int heldP2V, heldSlope, heldArea;
  bit pending = 0;
  string pendTag = "";
  int pendP2V, pendSlope, pendArea;
  bit finished = 0;

  task automatic check(string req, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void refModel();
    int mx = wbuf[0], mn = wbuf[0], sl = -4096, ar = wbuf[0];
    bit open = 1, neg = wbuf[0] < 0;
    for (int i = 1; i < wlen; i++) begin
      if (wbuf[i] > mx) mx = wbuf[i];
      if (wbuf[i] < mn) mn = wbuf[i];
      if (wbuf[i] - wbuf[i-1] > sl) sl = wbuf[i] - wbuf[i-1];
      if (open) begin
        if ((wbuf[i] < 0) != neg) open = 0;
        else ar += wbuf[i];
      end
    end
    expP2V = mx - mn; expSlope = sl; expArea = ar;
  endfunction

  // Called at a negedge: verify result of a window closed one cycle ago
  task automatic resolvePending();
    if (pending) begin
      check({pendTag, " R4 valid"}, int'(featValid), 1);
      check({pendTag, " R1 p2v"}, int'(featP2V), pendP2V);
      check({pendTag, " R2 slope"}, int'(featSlope), pendSlope);
      check({pendTag, " R3 area"}, int'(featArea), pendArea);
      heldP2V = pendP2V; heldSlope = pendSlope; heldArea = pendArea;
      pending = 0;
    end else begin
      check("R4 strobe low", int'(featValid), 0);
    end
  endtask

  task automatic idle(int cycles, bit stray);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      resolvePending();
      if (c > 0) begin
        check("R4 hold p2v", int'(featP2V), heldP2V);
        check("R4 hold area", int'(featArea), heldArea);
      end
      sampleValid = stray; winStart = 0; winEnd = 0;
      sampleData = 12'($urandom_range(0, 4095));
    end
  endtask

  // Drive wbuf[0..wlen-1]; gaps inserts invalid cycles (R6); noEnd omits the end marker
  task automatic sendWindow(string tag, bit gaps, bit noEnd);
    refModel();
    for (int i = 0; i < wlen; i++) begin
      if (gaps && i > 0 && $urandom_range(0, 3) == 0) begin
        @(negedge clk); resolvePending();
        sampleValid = 0; winStart = 0; winEnd = 0;
        sampleData = 12'($urandom_range(0, 4095));
      end
      @(negedge clk); resolvePending();
      sampleValid = 1; sampleData = 12'(wbuf[i]);
      winStart = (i == 0); winEnd = (i == wlen - 1) && !noEnd;
    end
    if (!noEnd) begin
      pending = 1; pendTag = tag;
      pendP2V = expP2V; pendSlope = expSlope; pendArea = expArea;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    check("R8 valid", int'(featValid), 0);
    check("R8 p2v", int'(featP2V), 0);
    check("R8 slope", int'(featSlope), 0);
    check("R8 area", int'(featArea), 0);
    @(negedge clk); @(negedge clk); rstN = 1;
    heldP2V = 0; heldSlope = 0; heldArea = 0;
    idle(2, 0);

    // R9: one-sample window, slope stays at floor
    wlen = 1; wbuf[0] = 0; sendWindow("R9 single", 0, 0); idle(2, 0);
    // R3 overflow corners
    wlen = 64; for (int i = 0; i < 64; i++) wbuf[i] = -2048;
    sendWindow("R3 allneg", 0, 0); idle(1, 0);
    for (int i = 0; i < 64; i++) wbuf[i] = 2047;
    sendWindow("R3 allpos", 0, 0); idle(1, 0);
    // R1 R2 extreme alternation
    wlen = 48; for (int i = 0; i < 48; i++) wbuf[i] = (i % 2) ? 2047 : -2048;
    sendWindow("R2 alt", 0, 0); idle(1, 0);
    // R3: zero keeps non-negative half-cycle going
    wlen = 6; wbuf[0] = 5; wbuf[1] = 0; wbuf[2] = 7; wbuf[3] = -1; wbuf[4] = 9; wbuf[5] = 0;
    sendWindow("R3 zero", 0, 0); idle(1, 0);
    // R6: stray valid samples outside a window
    idle(5, 1); idle(1, 0);
    // R7: restart: partial window then new start
    wlen = 5; for (int i = 0; i < 5; i++) wbuf[i] = 1500 - i * 700;
    sendWindow("R7 partial", 0, 1);
    wlen = 4; wbuf[0] = -10; wbuf[1] = -20; wbuf[2] = 30; wbuf[3] = -40;
    sendWindow("R7 restart", 0, 0); idle(2, 0);
    // R5: back-to-back windows
    wlen = 3; wbuf[0] = 100; wbuf[1] = 300; wbuf[2] = -50;
    sendWindow("R5 first", 0, 0);
    wlen = 2; wbuf[0] = -7; wbuf[1] = -3;
    sendWindow("R5 second", 0, 0);
    wlen = 1; wbuf[0] = -2048;
    sendWindow("R5 R9 third", 0, 0); idle(2, 0);

    // Random windows: spike-like and full-scale noise, with gaps (R6)
    for (int w = 0; w < 300; w++) begin
      wlen = $urandom_range(1, 64);
      if (w % 2) begin
        int run = $urandom_range(1, 64);
        bit s = $urandom_range(0, 1);
        for (int i = 0; i < wlen; i++) begin
          int m = $urandom_range(0, 2047);
          wbuf[i] = ((i < run) ^ s) ? m : -m - 1;
        end
      end else begin
        for (int i = 0; i < wlen; i++) wbuf[i] = int'($urandom_range(0, 4095)) - 2048;
      end
      sendWindow("rand R1 R2 R3 R6", w % 3 == 0, 0);
      if (w % 4 != 0) idle($urandom_range(1, 3), w % 5 == 0);
    end
    idle(2, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule